// File: doc/BRIEF.md
# Buffer Queue Interrupt Monitor

This block raises two host interrupts from the state of a packet memory. On the receive side it keeps a running count of frames waiting in the receive queue, fed by enqueue and dequeue strobes. It flags an interrupt when that count is above a host-programmed threshold. On the transmit side the host programs how much buffer space, in double-words, it needs for its next transmit. The block flags an interrupt once the reported free space covers that request.

Each source has its own enable input. Both results are kept as sticky bits in a 16-bit status word, with receive in bit 13 and transmit in bit 6. The host acknowledges a bit by writing one to it. The two programmable values can be read back. The frame count is also output so that the queue occupancy is visible.

Top module: `qmon_irq_top`

## Requirements
- R1: The receive threshold is an 8-bit register that resets to 0. A write with `thr_wr_en` high appears on `thr_rd` from the next cycle.
- R2: The transmit request is a 16-bit register, in double-words, that resets to 0. A write with `req_wr_en` high appears on `req_rd` from the next cycle.
- R3: `rx_count` resets to 0. It rises by one on a cycle with `rx_push` alone and falls by one on a cycle with `rx_pop` alone, and it is unchanged when both strobes are high. The new value shows one cycle after the strobe.
- R4: `rx_count` saturates. A push at 255 leaves it at 255, and a pop at 0 leaves it at 0.
- R5: While `rx_irq_en` is 1 and `rx_count` is greater than the threshold, status bit 13 is 1 on the following cycle.
- R6: While `rx_irq_en` is 0, status bit 13 is never set, whatever the count and the threshold.
- R7: While `tx_irq_en` is 1 and `free_dw` is at least the request, status bit 6 is 1 on the following cycle. A request of 0 is always met.
- R8: While `tx_irq_en` is 0, status bit 6 is never set.
- R9: A status bit that is set stays at 1 after its condition goes away, until it is acknowledged. Writing 0 to the bit leaves it unchanged.
- R10: A cycle with `stat_wr` high and bit 13 or bit 6 of `stat_wr_data` at 1 clears that status bit at the next edge and leaves the other bit alone. If the condition still holds, the bit is 1 again one cycle later.
- R11: All status bits other than 13 and 6 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | A frame was added to the receive queue |
| rx_pop | input | 1 | A frame was removed from the receive queue |
| free_dw | input | 16 | Free transmit space in double-words |
| thr_wr_en | input | 1 | Write strobe for the receive threshold |
| thr_wr_data | input | 8 | New receive threshold |
| req_wr_en | input | 1 | Write strobe for the transmit request |
| req_wr_data | input | 16 | New transmit request in double-words |
| rx_irq_en | input | 1 | Receive threshold interrupt enable |
| tx_irq_en | input | 1 | Transmit space interrupt enable |
| stat_wr | input | 1 | Status acknowledge strobe |
| stat_wr_data | input | 16 | Write-one-to-clear mask for the status word |
| thr_rd | output | 8 | Current receive threshold |
| req_rd | output | 16 | Current transmit request |
| rx_count | output | 8 | Frames held in the receive queue |
| stat | output | 16 | Sticky status word (bit 13 receive, bit 6 transmit) |

## Verification
The properties take the strobes to reflect the real queue: no dequeue is reported for an empty queue, and no enqueue is reported past the counter limit, except in the saturation cases that the bench provokes on purpose. They also take `free_dw` to be a plain level that is sampled every cycle, with no handshake. The stimulus changes inputs only on the falling clock edge. Before it checks a status bit, it acknowledges that bit and then waits one cycle, so the bit it reads comes only from the condition that is present at that moment.

// File: rtl/qmon_pkg.sv
`timescale 1ns/1ps
package qmon_pkg;
  localparam int STAT_W     = 16;
  localparam int RX_IRQ_BIT = 13;
  localparam int TX_IRQ_BIT = 6;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_act_e;

  // Decide the counter move from the strobes and the limits
  function automatic cnt_act_e cnt_action(input logic push, input logic pop,
                                          input logic at_max, input logic at_zero);
    cnt_act_e a;
    a = CNT_HOLD;
    if (push && !pop && !at_max)      a = CNT_UP;
    else if (pop && !push && !at_zero) a = CNT_DOWN;
    return a;
  endfunction
endpackage

// File: rtl/qmon_frame_ctr.sv
`timescale 1ns/1ps
module qmon_frame_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count
);
  import qmon_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic     at_max;
  logic     at_zero;
  cnt_act_e act;

  assign at_max  = (count == CNT_MAX);
  assign at_zero = (count == '0);

  always_comb act = cnt_action(push, pop, at_max, at_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case (act)
        CNT_UP:   count <= count + 1'b1;
        CNT_DOWN: count <= count - 1'b1;
        default:  count <= count;
      endcase
    end
  end
endmodule

// File: rtl/qmon_cfg_reg.sv
`timescale 1ns/1ps
module qmon_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)     value <= '0;
    else if (wr_en) value <= wr_data;
  end
endmodule

// File: rtl/qmon_sticky_bit.sv
`timescale 1ns/1ps
module qmon_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic q
);
  // Acknowledge wins over a new set; a held condition sets again a cycle later
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (cond) q <= 1'b1;
  end
endmodule

// File: rtl/qmon_irq_top.sv
`timescale 1ns/1ps
module qmon_irq_top #(
  parameter int CNT_W  = 8,
  parameter int THR_W  = 8,
  parameter int REQ_W  = 16,
  parameter int FREE_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_push,
  input  logic                        rx_pop,
  input  logic [FREE_W-1:0]           free_dw,
  input  logic                        thr_wr_en,
  input  logic [THR_W-1:0]            thr_wr_data,
  input  logic                        req_wr_en,
  input  logic [REQ_W-1:0]            req_wr_data,
  input  logic                        rx_irq_en,
  input  logic                        tx_irq_en,
  input  logic                        stat_wr,
  input  logic [qmon_pkg::STAT_W-1:0] stat_wr_data,
  output logic [THR_W-1:0]            thr_rd,
  output logic [REQ_W-1:0]            req_rd,
  output logic [CNT_W-1:0]            rx_count,
  output logic [qmon_pkg::STAT_W-1:0] stat
);
  import qmon_pkg::*;

  localparam int RX_CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
  localparam int TX_CMP_W = (FREE_W > REQ_W) ? FREE_W : REQ_W;
  localparam int N_SRC    = 2;

  localparam int SRC_BIT [N_SRC] = '{RX_IRQ_BIT, TX_IRQ_BIT};

  function automatic logic rx_over(input logic [CNT_W-1:0] c, input logic [THR_W-1:0] t);
    return RX_CMP_W'(c) > RX_CMP_W'(t);
  endfunction

  function automatic logic tx_fits(input logic [FREE_W-1:0] f, input logic [REQ_W-1:0] r);
    return TX_CMP_W'(f) >= TX_CMP_W'(r);
  endfunction

  logic             rx_hit;
  logic             tx_hit;
  logic [N_SRC-1:0] src_cond;
  logic [N_SRC-1:0] src_clr;
  logic [N_SRC-1:0] src_q;

  qmon_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .pop   (rx_pop),
    .count (rx_count)
  );

  qmon_cfg_reg #(.W(THR_W)) u_thr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (thr_wr_en),
    .wr_data (thr_wr_data),
    .value   (thr_rd)
  );

  qmon_cfg_reg #(.W(REQ_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_wr_en),
    .wr_data (req_wr_data),
    .value   (req_rd)
  );

  assign rx_hit   = rx_irq_en && rx_over(rx_count, thr_rd);
  assign tx_hit   = tx_irq_en && tx_fits(free_dw, req_rd);
  assign src_cond = {tx_hit, rx_hit};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_clr[g] = stat_wr && stat_wr_data[SRC_BIT[g]];
    qmon_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (src_cond[g]),
      .clr   (src_clr[g]),
      .q     (src_q[g])
    );
  end

  always_comb begin
    stat             = '0;
    stat[RX_IRQ_BIT] = src_q[0];
    stat[TX_IRQ_BIT] = src_q[1];
  end
endmodule

// File: rtl/qmon_irq_chk.sv
`timescale 1ns/1ps
module qmon_irq_chk #(
  parameter int CNT_W  = 8,
  parameter int THR_W  = 8,
  parameter int REQ_W  = 16,
  parameter int FREE_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rx_push,
  input logic                        rx_pop,
  input logic [FREE_W-1:0]           free_dw,
  input logic                        thr_wr_en,
  input logic [THR_W-1:0]            thr_wr_data,
  input logic                        req_wr_en,
  input logic [REQ_W-1:0]            req_wr_data,
  input logic                        rx_irq_en,
  input logic                        tx_irq_en,
  input logic                        stat_wr,
  input logic [qmon_pkg::STAT_W-1:0] stat_wr_data,
  input logic [THR_W-1:0]            thr_rd,
  input logic [REQ_W-1:0]            req_rd,
  input logic [CNT_W-1:0]            rx_count,
  input logic [qmon_pkg::STAT_W-1:0] stat
);
  import qmon_pkg::*;

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R1
  thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_en |=> thr_rd == $past(thr_wr_data));

  // R2
  req_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr_en |=> req_rd == $past(req_wr_data));

  // R3
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && rx_count != CMAX) |=> rx_count == CNT_W'($past(rx_count) + 1'b1));

  // R3
  count_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_pop) |=> $stable(rx_count));

  // R4
  count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push && rx_count == '0) |=> rx_count == '0);

  // R5
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq_en && rx_count > thr_rd && !(stat_wr && stat_wr_data[RX_IRQ_BIT])) |=> stat[RX_IRQ_BIT]);

  // R6
  rx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[RX_IRQ_BIT]) |-> $past(rx_irq_en && rx_count > thr_rd));

  // R7
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq_en && free_dw >= req_rd && !(stat_wr && stat_wr_data[TX_IRQ_BIT])) |=> stat[TX_IRQ_BIT]);

  // R8
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[TX_IRQ_BIT]) |-> $past(tx_irq_en && free_dw >= req_rd));

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[RX_IRQ_BIT] && !(stat_wr && stat_wr_data[RX_IRQ_BIT])) |=> stat[RX_IRQ_BIT]);

  // R10
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wr_data[RX_IRQ_BIT]) |=> !stat[RX_IRQ_BIT]);

  // R10
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wr_data[TX_IRQ_BIT]) |=> !stat[TX_IRQ_BIT]);

  // R11
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stat) == $countones({stat[RX_IRQ_BIT], stat[TX_IRQ_BIT]}));
endmodule

bind qmon_irq_top qmon_irq_chk #(
  .CNT_W(CNT_W), .THR_W(THR_W), .REQ_W(REQ_W), .FREE_W(FREE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop), .free_dw(free_dw),
  .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data), .req_wr_en(req_wr_en),
  .req_wr_data(req_wr_data), .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
  .stat_wr(stat_wr), .stat_wr_data(stat_wr_data), .thr_rd(thr_rd), .req_rd(req_rd),
  .rx_count(rx_count), .stat(stat)
);

// File: tb/test_qmon_irq_top.sv
`timescale 1ns/1ps
module test_qmon_irq_top;
  localparam int RXB = 13;
  localparam int TXB = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_push = 1'b0, rx_pop = 1'b0;
  logic [15:0] free_dw = '0;
  logic        thr_wr_en = 1'b0;
  logic [7:0]  thr_wr_data = '0;
  logic        req_wr_en = 1'b0;
  logic [15:0] req_wr_data = '0;
  logic        rx_irq_en = 1'b0, tx_irq_en = 1'b0;
  logic        stat_wr = 1'b0;
  logic [15:0] stat_wr_data = '0;
  logic [7:0]  thr_rd;
  logic [15:0] req_rd;
  logic [7:0]  rx_count;
  logic [15:0] stat;

  int checks = 0;
  int errors = 0;
  int model_cnt = 0;
  int model_thr = 0;
  int model_req = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  qmon_irq_top i_qmon_irq_top (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop), .free_dw(free_dw),
    .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data), .req_wr_en(req_wr_en),
    .req_wr_data(req_wr_data), .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
    .stat_wr(stat_wr), .stat_wr_data(stat_wr_data), .thr_rd(thr_rd), .req_rd(req_rd),
    .rx_count(rx_count), .stat(stat)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_n(input int n);
    if (n > 0) begin
      rx_push = 1'b1;
      repeat (n) @(negedge clk);
      rx_push = 1'b0;
      model_cnt = (model_cnt + n > 255) ? 255 : model_cnt + n;
    end
  endtask

  task automatic pop_n(input int n);
    if (n > 0) begin
      rx_pop = 1'b1;
      repeat (n) @(negedge clk);
      rx_pop = 1'b0;
      model_cnt = (model_cnt - n < 0) ? 0 : model_cnt - n;
    end
  endtask

  task automatic set_thr(input int v);
    thr_wr_en = 1'b1; thr_wr_data = 8'(v);
    @(negedge clk);
    thr_wr_en = 1'b0;
    model_thr = v;
  endtask

  task automatic set_req(input int v);
    req_wr_en = 1'b1; req_wr_data = 16'(v);
    @(negedge clk);
    req_wr_en = 1'b0;
    model_req = v;
  endtask

  task automatic ack(input logic [15:0] mask);
    stat_wr = 1'b1; stat_wr_data = mask;
    @(negedge clk);
    stat_wr = 1'b0; stat_wr_data = '0;
  endtask

  // Clear a bit, let one edge pass, then compare it with the live condition
  task automatic probe(input string tag, input int b, input int exp);
    ack(16'(1 << b));
    @(negedge clk);
    check(tag, int'(stat[b]), exp);
    check("R11 spare bits", int'(stat & ~((16'(1) << RXB) | (16'(1) << TXB))), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset thr", int'(thr_rd), 0);
    check("R2 reset req", int'(req_rd), 0);
    check("R3 reset count", int'(rx_count), 0);
    check("R11 reset stat", int'(stat), 0);

    // Floor and both-strobe cases
    pop_n(3);
    check("R4 pop at zero", int'(rx_count), 0);
    push_n(4);
    check("R3 push four", int'(rx_count), model_cnt);
    rx_push = 1'b1; rx_pop = 1'b1;
    repeat (3) @(negedge clk);
    rx_push = 1'b0; rx_pop = 1'b0;
    check("R3 push and pop together", int'(rx_count), 4);
    pop_n(1);
    check("R3 single pop", int'(rx_count), 3);
    pop_n(model_cnt);

    // Register readback
    set_thr(8'hA5);
    check("R1 thr readback", int'(thr_rd), 8'hA5);
    set_req(16'hBEEF);
    check("R2 req readback", int'(req_rd), 16'hBEEF);

    // Receive sweep over threshold and count
    rx_irq_en = 1'b1;
    for (int t = 0; t < 6; t++) begin
      set_thr(t);
      pop_n(model_cnt);
      for (int c = 0; c < 8; c++) begin
        check("R3 sweep count", int'(rx_count), c);
        probe("R5 rx threshold sweep", RXB, (c > t) ? 1 : 0);
        push_n(1);
      end
    end

    // Disabled receive source
    rx_irq_en = 1'b0;
    set_thr(0);
    probe("R6 rx disabled", RXB, 0);
    repeat (4) @(negedge clk);
    check("R6 rx disabled hold", int'(stat[RXB]), 0);

    // Saturation at the top
    push_n(300);
    check("R4 saturate high", int'(rx_count), 255);
    push_n(1);
    check("R4 push at max", int'(rx_count), 255);
    pop_n(1);
    check("R3 pop from max", int'(rx_count), 254);
    pop_n(model_cnt);

    // Sticky and acknowledge behaviour
    rx_irq_en = 1'b1;
    push_n(1);
    @(negedge clk);
    check("R5 rx set", int'(stat[RXB]), 1);
    pop_n(1);
    repeat (5) @(negedge clk);
    check("R9 rx sticky after condition gone", int'(stat[RXB]), 1);
    ack(16'h0000);
    check("R9 write zero keeps bit", int'(stat[RXB]), 1);
    ack(16'(1 << RXB));
    check("R10 rx cleared", int'(stat[RXB]), 0);
    repeat (3) @(negedge clk);
    check("R10 rx stays clear", int'(stat[RXB]), 0);
    push_n(1);
    @(negedge clk);
    ack(16'(1 << RXB));
    check("R10 cleared while held", int'(stat[RXB]), 0);
    @(negedge clk);
    check("R10 sets again", int'(stat[RXB]), 1);

    // Transmit sweep, near exhaustive over small values
    tx_irq_en = 1'b1;
    for (int r = 0; r < 8; r++) begin
      set_req(r);
      for (int f = 0; f < 8; f++) begin
        free_dw = 16'(f);
        probe("R7 tx space sweep", TXB, (f >= r) ? 1 : 0);
      end
    end
    set_req(16'hFFFF);
    free_dw = 16'hFFFE;
    probe("R7 tx large short", TXB, 0);
    free_dw = 16'hFFFF;
    probe("R7 tx large exact", TXB, 1);
    set_req(0);
    free_dw = 16'h0000;
    probe("R7 tx zero request", TXB, 1);

    // Independence of the two bits
    check("R10 rx still set", int'(stat[RXB]), 1);
    set_req(16'h0010);
    free_dw = 16'h0001;
    ack(16'(1 << TXB));
    @(negedge clk);
    check("R10 tx cleared alone", int'(stat[TXB]), 0);
    check("R10 rx untouched by tx ack", int'(stat[RXB]), 1);

    // Disabled transmit source
    tx_irq_en = 1'b0;
    set_req(0);
    probe("R8 tx disabled", TXB, 0);
    repeat (4) @(negedge clk);
    check("R8 tx disabled hold", int'(stat[TXB]), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule